// File: doc/BRIEF.md
# Similarity-Model Inlier Counter

This block removes false point correspondences from a set of matches between two video frames. Each stored correspondence pairs a point in the previous frame (xb, yb) with a point in the current frame (xa, ya). Both points use 11-bit unsigned coordinates. The block builds one candidate model from every pair of stored correspondences. A model combines rotation, isotropic scale and translation, and its coefficients use a fixed-point factor of 256. The block then tests all stored correspondences against the model in parallel and counts the inliers.

A new sample pair enters the pipeline every cycle. The pair sequencer visits every unordered pair exactly once, so a set of N correspondences takes N(N-1)/2 cycles, plus a short drain. A correspondence is marked as a true match when it is an inlier of any model supported by more than five inliers. The best count seen during the run is also reported.

Software or an upstream matcher loads the correspondence store while the block is idle. It then pulses the start input and collects the per-pair counts, the keep mask and the best count when done rises.

Top module: `ransac_sim_counter`

## Requirements
- R1: A write on `ld_en` stores (xa, ya, xb, yb) at slot `ld_idx` when the block is idle. A write while `busy` is high is ignored.
- R2: A run presents every pair (i, j) with i < j exactly once, one pair per cycle. The outer index is i and the inner index is j, both ascending, which gives N(N-1)/2 pairs.
- R3: With dx = xb_i − xb_j, dy = yb_i − yb_j, Dx = xa_i − xa_j and Dy = ya_i − ya_j, the coefficients are A = 256(Dx·dx + Dy·dy)/(dx²+dy²) and B = 256(Dy·dx − Dx·dy)/(dx²+dy²). Both use signed division that truncates toward zero.
- R4: The translations come from the first point of the pair: tx = 256·xa_i − A·xb_i + B·yb_i and ty = 256·ya_i − B·xb_i − A·yb_i.
- R5: A pair with dx = dy = 0 produces no result and does not touch the keep mask or the best count.
- R6: Correspondence q is an inlier when |A·xb_q − B·yb_q + tx − 256·xa_q| + |B·xb_q + A·yb_q + ty − 256·ya_q| ≤ 512. `res_count` is the number of inliers, and `res_i`/`res_j` give the pair. The k-th pair of a run (k from 0) shows `res_valid` exactly k+3 clock edges after the edge that accepted start.
- R7: `keep_mask` is cleared when a run starts. Afterwards it is the OR of the inlier masks of every model whose count exceeds 5. Bit q corresponds to slot q.
- R8: `best_count` is cleared when a run starts. Afterwards it holds the largest `res_count` of the run.
- R9: `done` is a one-cycle pulse that arrives N(N-1)/2 + 2 edges after the accepting edge, together with the last pair's result slot. `busy` is low from that cycle on, and a start pulse while `busy` is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ld_en | input | 1 | Store write strobe |
| ld_idx | input | IDX_W | Store slot to write |
| ld_xa | input | 11 | Current-frame x |
| ld_ya | input | 11 | Current-frame y |
| ld_xb | input | 11 | Previous-frame x |
| ld_yb | input | 11 | Previous-frame y |
| start | input | 1 | Begin a run (accepted only when idle) |
| busy | output | 1 | Run or drain in progress |
| res_valid | output | 1 | Per-pair result valid |
| res_i | output | IDX_W | First slot of the pair |
| res_j | output | IDX_W | Second slot of the pair |
| res_count | output | CNT_W | Inlier count of the pair's model |
| done | output | 1 | End-of-run pulse |
| keep_mask | output | N_MATCH | Correspondences kept as true matches |
| best_count | output | CNT_W | Largest count of the run |

## Verification
The bench builds the block with N_MATCH = 8, which gives 28 pairs per run. At that size every result of every run can be predicted in 64-bit arithmetic and compared, including its cycle of arrival. The test sets cover pure translation with outliers, a 90° rotation with a scale of two, a 45° rotation whose truncation errors must stay within tolerance, and coincident previous-frame points that force skipped pairs. A run is also repeated with a store write and a second start injected while busy, so the two "ignored" rules show up at the ports.

// File: rtl/ransac_sim_pkg.sv
package ransac_sim_pkg;

  localparam int COORD_W = 11;
  localparam int WIDE_W  = 48;
  localparam int FRAC_SH = 8;

  typedef logic signed [WIDE_W-1:0] wide_t;

  typedef struct packed {
    logic [COORD_W-1:0] xa;
    logic [COORD_W-1:0] ya;
    logic [COORD_W-1:0] xb;
    logic [COORD_W-1:0] yb;
  } corr_t;

  function automatic wide_t widen(input logic [COORD_W-1:0] c);
    return $signed({{(WIDE_W-COORD_W){1'b0}}, c});
  endfunction

  function automatic wide_t mag(input wide_t v);
    return v[WIDE_W-1] ? -v : v;
  endfunction

  function automatic wide_t upscale(input wide_t v);
    return v <<< FRAC_SH;
  endfunction

  // translation that makes the sample point land exactly on itself
  function automatic wide_t shift_x(input wide_t a, input wide_t b, input corr_t c);
    return upscale(widen(c.xa)) - a * widen(c.xb) + b * widen(c.yb);
  endfunction

  function automatic wide_t shift_y(input wide_t a, input wide_t b, input corr_t c);
    return upscale(widen(c.ya)) - b * widen(c.xb) - a * widen(c.yb);
  endfunction

  // mapped previous-frame point minus scaled current-frame point
  function automatic wide_t miss_x(input wide_t a, input wide_t b, input wide_t tx, input corr_t c);
    return a * widen(c.xb) - b * widen(c.yb) + tx - upscale(widen(c.xa));
  endfunction

  function automatic wide_t miss_y(input wide_t a, input wide_t b, input wide_t ty, input corr_t c);
    return b * widen(c.xb) + a * widen(c.yb) + ty - upscale(widen(c.ya));
  endfunction

endpackage

// File: rtl/ransac_pair_seq.sv
module ransac_pair_seq
  import ransac_sim_pkg::*;
#(
  parameter int N_MATCH = 16,
  parameter int IDX_W   = $clog2(N_MATCH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  output logic             busy,
  output logic             start_ok,
  output logic             pv,
  output logic             plast,
  output logic [IDX_W-1:0] pi,
  output logic [IDX_W-1:0] pj
);

  localparam logic [IDX_W-1:0] LAST_I = IDX_W'(N_MATCH - 2);
  localparam logic [IDX_W-1:0] LAST_J = IDX_W'(N_MATCH - 1);

  typedef enum logic [1:0] {S_IDLE, S_RUN, S_DRAIN} seq_st_e;

  seq_st_e st_q;
  logic    drain_q;

  assign busy     = (st_q != S_IDLE);
  assign start_ok = start && (st_q == S_IDLE);
  assign pv       = (st_q == S_RUN);
  assign plast    = pv && (pi == LAST_I) && (pj == LAST_J);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= S_IDLE;
      drain_q <= 1'b0;
      pi      <= '0;
      pj      <= '0;
    end else begin
      unique case (st_q)
        S_IDLE: if (start) begin
          st_q <= S_RUN;
          pi   <= '0;
          pj   <= IDX_W'(1);
        end
        S_RUN: begin
          if (plast) begin
            st_q    <= S_DRAIN;
            drain_q <= 1'b0;
          end else if (pj == LAST_J) begin
            pi <= pi + IDX_W'(1);
            pj <= pi + IDX_W'(2);
          end else begin
            pj <= pj + IDX_W'(1);
          end
        end
        S_DRAIN: begin
          if (drain_q) st_q <= S_IDLE;
          drain_q <= 1'b1;
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end

  p_pair_ordered_r2: assert property (@(posedge clk) disable iff (!rst_n)
    pv |-> (pi < pj));

  p_pair_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (pv && $past(pv)) |-> ((pi == $past(pi) && pj == $past(pj) + IDX_W'(1)) ||
                           (pi == $past(pi) + IDX_W'(1) && pj == pi + IDX_W'(1))));

endmodule

// File: rtl/ransac_model_fit.sv
module ransac_model_fit
  import ransac_sim_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  p_vld,
  input  logic  p_last,
  input  corr_t p_first,
  input  corr_t p_second,
  output logic  m_vld,
  output logic  m_last,
  output wide_t m_a,
  output wide_t m_b,
  output wide_t m_tx,
  output wide_t m_ty
);

  localparam wide_t UNITY = wide_t'(1) <<< FRAC_SH;

  wide_t dxb, dyb, dxa, dya, den, den_safe, num_a, num_b;
  logic  degen;

  always_comb begin
    dxb      = widen(p_first.xb) - widen(p_second.xb);
    dyb      = widen(p_first.yb) - widen(p_second.yb);
    dxa      = widen(p_first.xa) - widen(p_second.xa);
    dya      = widen(p_first.ya) - widen(p_second.ya);
    den      = dxb * dxb + dyb * dyb;
    degen    = (den == '0);
    den_safe = degen ? wide_t'(1) : den;
    num_a    = upscale(dxa * dxb + dya * dyb);
    num_b    = upscale(dya * dxb - dxa * dyb);
  end

  // stage 1: registered quotients, sample point carried alongside
  logic  s1_vld, s1_last;
  wide_t s1_a, s1_b;
  corr_t s1_pt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_vld  <= 1'b0;
      s1_last <= 1'b0;
      s1_a    <= '0;
      s1_b    <= '0;
      s1_pt   <= '0;
    end else begin
      s1_vld  <= p_vld && !degen;
      s1_last <= p_vld && p_last;
      s1_a    <= num_a / den_safe;
      s1_b    <= num_b / den_safe;
      s1_pt   <= p_first;
    end
  end

  // stage 2: translation from the delayed first sample point
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_vld  <= 1'b0;
      m_last <= 1'b0;
      m_a    <= '0;
      m_b    <= '0;
      m_tx   <= '0;
      m_ty   <= '0;
    end else begin
      m_vld  <= s1_vld;
      m_last <= s1_last;
      m_a    <= s1_a;
      m_b    <= s1_b;
      m_tx   <= shift_x(s1_a, s1_b, s1_pt);
      m_ty   <= shift_y(s1_a, s1_b, s1_pt);
    end
  end

  // identical displacement in both frames must give an exact unit model
  p_unity_fit_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (p_vld && !degen && dxa == dxb && dya == dyb) |=> (s1_a == UNITY && s1_b == '0));

  p_skip_stays_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (s1_vld && !m_vld) |=> m_vld);

endmodule

// File: rtl/ransac_inlier_array.sv
module ransac_inlier_array
  import ransac_sim_pkg::*;
#(
  parameter int N_MATCH = 16,
  parameter int TOL_PX  = 2,
  parameter int CNT_W   = $clog2(N_MATCH + 1)
) (
  input  corr_t              pts [N_MATCH],
  input  wide_t              a,
  input  wide_t              b,
  input  wide_t              tx,
  input  wide_t              ty,
  output logic [N_MATCH-1:0] mask,
  output logic [CNT_W-1:0]   count
);

  localparam wide_t TOL = wide_t'(TOL_PX) <<< FRAC_SH;

  for (genvar q = 0; q < N_MATCH; q++) begin : g_test
    wide_t rx, ry;
    assign rx      = miss_x(a, b, tx, pts[q]);
    assign ry      = miss_y(a, b, ty, pts[q]);
    assign mask[q] = (mag(rx) + mag(ry)) <= TOL;
  end

  always_comb begin
    count = '0;
    for (int q = 0; q < N_MATCH; q++) count = count + CNT_W'(mask[q]);
  end

endmodule

// File: rtl/ransac_sim_counter.sv
module ransac_sim_counter
  import ransac_sim_pkg::*;
#(
  parameter  int N_MATCH  = 16,
  parameter  int KEEP_MIN = 5,
  parameter  int TOL_PX   = 2,
  localparam int IDX_W    = $clog2(N_MATCH),
  localparam int CNT_W    = $clog2(N_MATCH + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ld_en,
  input  logic [IDX_W-1:0]   ld_idx,
  input  logic [COORD_W-1:0] ld_xa,
  input  logic [COORD_W-1:0] ld_ya,
  input  logic [COORD_W-1:0] ld_xb,
  input  logic [COORD_W-1:0] ld_yb,
  input  logic               start,
  output logic               busy,
  output logic               res_valid,
  output logic [IDX_W-1:0]   res_i,
  output logic [IDX_W-1:0]   res_j,
  output logic [CNT_W-1:0]   res_count,
  output logic               done,
  output logic [N_MATCH-1:0] keep_mask,
  output logic [CNT_W-1:0]   best_count
);

  localparam logic [CNT_W-1:0] KEEP_LIM = CNT_W'(KEEP_MIN);

  corr_t store_q [N_MATCH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int q = 0; q < N_MATCH; q++) store_q[q] <= '0;
    end else if (ld_en && !busy) begin
      store_q[ld_idx] <= '{xa: ld_xa, ya: ld_ya, xb: ld_xb, yb: ld_yb};
    end
  end

  logic             start_ok, pv, plast;
  logic [IDX_W-1:0] pi, pj;

  ransac_pair_seq #(.N_MATCH(N_MATCH), .IDX_W(IDX_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .start_ok(start_ok),
    .pv(pv), .plast(plast), .pi(pi), .pj(pj)
  );

  logic  m_vld, m_last;
  wide_t m_a, m_b, m_tx, m_ty;

  ransac_model_fit u_fit (
    .clk(clk), .rst_n(rst_n), .p_vld(pv), .p_last(plast),
    .p_first(store_q[pi]), .p_second(store_q[pj]),
    .m_vld(m_vld), .m_last(m_last), .m_a(m_a), .m_b(m_b), .m_tx(m_tx), .m_ty(m_ty)
  );

  logic [N_MATCH-1:0] inl_mask;
  logic [CNT_W-1:0]   inl_cnt;

  ransac_inlier_array #(.N_MATCH(N_MATCH), .TOL_PX(TOL_PX), .CNT_W(CNT_W)) u_test (
    .pts(store_q), .a(m_a), .b(m_b), .tx(m_tx), .ty(m_ty),
    .mask(inl_mask), .count(inl_cnt)
  );

  // pair indices follow the two fit stages
  logic [IDX_W-1:0] pi_d1, pj_d1, pi_d2, pj_d2;
  logic             model_keeps;
  assign model_keeps = m_vld && (inl_cnt > KEEP_LIM);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pi_d1 <= '0; pj_d1 <= '0; pi_d2 <= '0; pj_d2 <= '0;
      res_valid  <= 1'b0;
      res_i      <= '0;
      res_j      <= '0;
      res_count  <= '0;
      done       <= 1'b0;
      keep_mask  <= '0;
      best_count <= '0;
    end else begin
      pi_d1     <= pi;    pj_d1 <= pj;
      pi_d2     <= pi_d1; pj_d2 <= pj_d1;
      res_valid <= m_vld;
      done      <= m_last;
      if (m_vld) begin
        res_i     <= pi_d2;
        res_j     <= pj_d2;
        res_count <= inl_cnt;
      end
      if (start_ok) begin
        keep_mask  <= '0;
        best_count <= '0;
      end else begin
        if (model_keeps) keep_mask <= keep_mask | inl_mask;
        if (m_vld && inl_cnt > best_count) best_count <= inl_cnt;
      end
    end
  end

  // the first sample point always maps onto itself
  p_self_inlier_r6: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> (res_count != '0));

  p_keep_grows_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !start_ok |=> ((keep_mask & $past(keep_mask)) == $past(keep_mask)));

  p_best_floor_r8: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> (best_count >= res_count));

  p_done_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  p_store_frozen_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $past(busy) && busy |-> $stable(store_q[0]));

endmodule

// File: tb/ransac_sim_counter_bench.sv
module ransac_sim_counter_bench;
  import ransac_sim_pkg::*;

  localparam int CLK_PERIOD = 10;
  localparam int NM = 8;
  localparam int IW = 3;
  localparam int CWN = 4;
  localparam int NP = NM * (NM - 1) / 2;
  localparam int KM = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ld_en = 1'b0;
  logic [IW-1:0] ld_idx = '0;
  logic [COORD_W-1:0] ld_xa = '0, ld_ya = '0, ld_xb = '0, ld_yb = '0;
  logic start = 1'b0;
  logic busy, res_valid, done;
  logic [IW-1:0] res_i, res_j;
  logic [CWN-1:0] res_count, best_count;
  logic [NM-1:0] keep_mask;

  always #(CLK_PERIOD/2) clk = ~clk;

  ransac_sim_counter #(.N_MATCH(NM), .KEEP_MIN(KM), .TOL_PX(2)) u_ransac_sim_counter (
    .clk(clk), .rst_n(rst_n), .ld_en(ld_en), .ld_idx(ld_idx),
    .ld_xa(ld_xa), .ld_ya(ld_ya), .ld_xb(ld_xb), .ld_yb(ld_yb),
    .start(start), .busy(busy), .res_valid(res_valid), .res_i(res_i), .res_j(res_j),
    .res_count(res_count), .done(done), .keep_mask(keep_mask), .best_count(best_count)
  );

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int unsigned seed = 32'h1234_5678;

  longint pxa[NM], pya[NM], pxb[NM], pyb[NM];
  int exp_n, exp_best;
  int exp_k[NP], exp_i[NP], exp_j[NP], exp_c[NP];
  logic [NM-1:0] exp_keep;

  task automatic check(input bit ok, input string tag, input longint act, input longint expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, expv);
    end
  endtask

  function automatic longint absl(input longint v);
    return (v < 0) ? -v : v;
  endfunction

  function automatic longint rnd();
    seed = seed * 32'd1103515245 + 32'd12345;
    return longint'((seed >> 8) & 32'h7ff);
  endfunction

  // independent model: fit every pair, count inliers in 64-bit arithmetic
  task automatic build_expected();
    int k = 0;
    exp_n = 0; exp_best = 0; exp_keep = '0;
    for (int i = 0; i < NM; i++) begin
      for (int j = i + 1; j < NM; j++) begin
        longint ex = pxb[i] - pxb[j], ey = pyb[i] - pyb[j];
        longint fx = pxa[i] - pxa[j], fy = pya[i] - pya[j];
        longint nrm = ex * ex + ey * ey;
        if (nrm != 0) begin
          longint ca = (256 * (fx * ex + fy * ey)) / nrm;
          longint sb = (256 * (fy * ex - fx * ey)) / nrm;
          longint ox = 256 * pxa[i] - ca * pxb[i] + sb * pyb[i];
          longint oy = 256 * pya[i] - sb * pxb[i] - ca * pyb[i];
          int hits = 0;
          logic [NM-1:0] hm = '0;
          for (int q = 0; q < NM; q++) begin
            longint ux = ca * pxb[q] - sb * pyb[q] + ox - 256 * pxa[q];
            longint uy = sb * pxb[q] + ca * pyb[q] + oy - 256 * pya[q];
            if (absl(ux) + absl(uy) <= 512) begin hits++; hm[q] = 1'b1; end
          end
          exp_k[exp_n] = k; exp_i[exp_n] = i; exp_j[exp_n] = j; exp_c[exp_n] = hits;
          exp_n++;
          if (hits > KM) exp_keep = exp_keep | hm;
          if (hits > exp_best) exp_best = hits;
        end
        k++;
      end
    end
  endtask

  task automatic load_all();
    for (int q = 0; q < NM; q++) begin
      @(negedge clk);
      ld_en = 1'b1; ld_idx = IW'(q);
      ld_xa = COORD_W'(pxa[q]); ld_ya = COORD_W'(pya[q]);
      ld_xb = COORD_W'(pxb[q]); ld_yb = COORD_W'(pyb[q]);
    end
    @(negedge clk);
    ld_en = 1'b0;
  endtask

  task automatic run_check(input string name);
    int m = 0;
    int got = 0;
    bit fin = 0;
    build_expected();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    while (!fin && m < NP + 20) begin
      @(negedge clk);
      m++;
      if (res_valid) begin
        if (got < exp_n) begin
          // R2 R6 pair, count and arrival cycle of each result
          check(res_i == IW'(exp_i[got]) && res_j == IW'(exp_j[got]) &&
                int'(res_count) == exp_c[got] && m == exp_k[got] + 3,
                $sformatf("R6 %s pair %0d/%0d count", name, exp_i[got], exp_j[got]),
                longint'(res_count), longint'(exp_c[got]));
        end else begin
          check(1'b0, $sformatf("R5 %s extra result", name), got + 1, exp_n);
        end
        got++;
      end
      if (done) begin
        check(m == NP + 2, $sformatf("R9 %s done cycle", name), m, NP + 2);
        fin = 1;
      end
    end
    check(fin, $sformatf("R9 %s done seen", name), fin, 1);
    check(got == exp_n, $sformatf("R5 %s result total", name), got, exp_n);
    check(keep_mask == exp_keep, $sformatf("R7 %s keep mask", name), keep_mask, exp_keep);
    check(int'(best_count) == exp_best, $sformatf("R8 %s best count", name), best_count, exp_best);
    check(!busy, $sformatf("R9 %s idle at done", name), busy, 0);
    @(negedge clk);
    check(!done, $sformatf("R9 %s done single pulse", name), done, 0);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000) begin
        errors++;
        checks++;
        $display("FAIL watchdog: actual %0d expected below 100000 cycles", cyc);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(!busy && !res_valid && !done, "R9 reset idle", {busy, res_valid, done}, 0);
    check(keep_mask == '0 && best_count == '0, "R7 reset keep", keep_mask, 0);

    // set 1: translation (+5,+3), two outliers; R1 R3 R4
    for (int q = 0; q < NM; q++) begin
      pxb[q] = 100 + 37 * q; pyb[q] = 200 + 23 * q;
      pxa[q] = pxb[q] + 5;   pya[q] = pyb[q] + 3;
    end
    pxa[6] = 900; pya[7] = 50;
    load_all();
    run_check("translate");

    // set 2: 90 degree rotation, scale two, one outlier; R3 R4
    for (int q = 0; q < NM; q++) begin
      pxb[q] = 100 + 31 * q; pyb[q] = 150 + 29 * (q % 5) + 7 * q;
      pxa[q] = 1500 - 2 * pyb[q]; pya[q] = 2 * pxb[q] + 10;
    end
    pxa[3] = 40;
    load_all();
    run_check("rotate90");

    // set 3: 45 degree rotation with truncated coordinates; R6 tolerance
    for (int q = 0; q < NM; q++) begin
      pxb[q] = 300 + 41 * q; pyb[q] = 120 + 17 * q + 5 * (q % 3);
      pxa[q] = (181 * pxb[q] - 181 * pyb[q]) / 256 + 1000;
      pya[q] = (181 * pxb[q] + 181 * pyb[q]) / 256 + 20;
    end
    load_all();
    run_check("rotate45");

    // set 4: coincident previous-frame points, random current points; R5
    for (int q = 0; q < NM; q++) begin
      pxb[q] = (q < 3) ? 777 : rnd(); pyb[q] = (q < 3) ? 555 : rnd();
      pxa[q] = rnd(); pya[q] = rnd();
    end
    load_all();
    run_check("degenerate");

    // set 1 again, with a store write and a second start while busy; R1 R9
    for (int q = 0; q < NM; q++) begin
      pxb[q] = 100 + 37 * q; pyb[q] = 200 + 23 * q;
      pxa[q] = pxb[q] + 5;   pya[q] = pyb[q] + 3;
    end
    pxa[6] = 900; pya[7] = 50;
    load_all();
    fork
      run_check("busy_ignore");
      begin
        repeat (6) @(negedge clk);
        ld_en = 1'b1; ld_idx = '0; ld_xa = 11'd2000; ld_ya = 11'd9; ld_xb = 11'd1; ld_yb = 11'd1;
        start = 1'b1;
        @(negedge clk);
        ld_en = 1'b0; start = 1'b0;
      end
    join
    run_check("store_kept_r1");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule